// File: doc/BRIEF.md
# Control-Bit Ripple-Carry ALU

A combinational arithmetic and logic unit made of identical one-bit slices. Each of the two operands goes through a conditioning stage. That stage can pass the operand through, invert it, force it to all zeros or force it to all ones. A function bit then picks either the sum or the bitwise AND of the conditioned operands. An output bit can invert the result, and a final selector can replace it with an immediate value.

The six control bits share one port, `ctl`, with this bit order: `ctl[5]` zeroes X, `ctl[4]` inverts X, `ctl[3]` zeroes Y, `ctl[2]` inverts Y, `ctl[1]` selects the function, and `ctl[0]` inverts the output. On each operand the zeroing acts first and the inversion second. This combined control gives the usual operations, such as constants, negation, increment, subtraction, AND and OR. The carry into bit 0 is zero, and the carry out of the top bit is not built. The block has no flags, registers or clock.

Top module: `ripple_alu`

## Requirements
- R1: The conditioned X operand follows `ctl[5]`/`ctl[4]`: 00 gives X, 01 gives NOT X, 10 gives all zeros and 11 gives all ones.
- R2: The conditioned Y operand follows `ctl[3]`/`ctl[2]` with the same four cases as R1.
- R3: With `ctl[1]`=1 the unit result is the sum of the conditioned operands modulo 2^WIDTH, with a carry-in of zero.
- R4: With `ctl[1]`=0 the unit result is the bitwise AND of the conditioned operands.
- R5: With `ctl[0]`=1 every bit of the unit result is inverted. With `ctl[0]`=0 it passes through unchanged.
- R6: With `sel_imm`=1, `res` equals `imm` whatever `x`, `y` and `ctl` are. With `sel_imm`=0, `res` is the unit result.
- R7: The standard control codes give these results: 101010 gives 0, 111111 gives 1, 111010 gives -1, 001100 gives x, 110000 gives y, 001101 gives ~x, 110001 gives ~y, 001111 gives -x, 110011 gives -y, 011111 gives x+1, 110111 gives y+1, 001110 gives x-1, 110010 gives y-1, 000010 gives x+y, 010011 gives x-y, 000111 gives y-x, 000000 gives x&y and 010101 gives x|y.
- R8: A carry propagates through every slice. An all-ones value plus one wraps to zero, and the carry out of the top bit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand |
| ctl | input | 6 | Control bits {zero X, invert X, zero Y, invert Y, function, invert out} |
| imm | input | WIDTH | Immediate value |
| sel_imm | input | 1 | 1 selects the immediate onto `res` |
| res | output | WIDTH | Result |

## Verification
Every result is purely combinational, so it is due in the same cycle as the stimulus, with no register in the path. The bench changes inputs just after a rising edge of its pacing clock and samples `res` at the following falling edge. That leaves half a period for the ripple chain to settle and keeps the sampling away from any clock edge. The bench computes each expected value from the operands and the control code, using plain arithmetic for the standard codes.

// File: rtl/ralu_pkg.sv
package ralu_pkg;
   localparam int CTL_W = 6;
   // control bit positions
   localparam int B_ZX = 5;
   localparam int B_NX = 4;
   localparam int B_ZY = 3;
   localparam int B_NY = 2;
   localparam int B_F  = 1;
   localparam int B_NO = 0;
   // standard operation codes
   localparam logic [CTL_W-1:0] OP_ZERO = 6'b101010;
   localparam logic [CTL_W-1:0] OP_ONE  = 6'b111111;
   localparam logic [CTL_W-1:0] OP_MONE = 6'b111010;
   localparam logic [CTL_W-1:0] OP_X    = 6'b001100;
   localparam logic [CTL_W-1:0] OP_Y    = 6'b110000;
   localparam logic [CTL_W-1:0] OP_NOTX = 6'b001101;
   localparam logic [CTL_W-1:0] OP_NOTY = 6'b110001;
   localparam logic [CTL_W-1:0] OP_NEGX = 6'b001111;
   localparam logic [CTL_W-1:0] OP_NEGY = 6'b110011;
   localparam logic [CTL_W-1:0] OP_XP1  = 6'b011111;
   localparam logic [CTL_W-1:0] OP_YP1  = 6'b110111;
   localparam logic [CTL_W-1:0] OP_XM1  = 6'b001110;
   localparam logic [CTL_W-1:0] OP_YM1  = 6'b110010;
   localparam logic [CTL_W-1:0] OP_ADD  = 6'b000010;
   localparam logic [CTL_W-1:0] OP_XMY  = 6'b010011;
   localparam logic [CTL_W-1:0] OP_YMX  = 6'b000111;
   localparam logic [CTL_W-1:0] OP_AND  = 6'b000000;
   localparam logic [CTL_W-1:0] OP_OR   = 6'b010101;
endpackage

// File: rtl/alu_cond.sv
module alu_cond #(
   parameter int W = 16
) (
   input  logic [W-1:0] raw,
   input  logic         zero_en,
   input  logic         inv_en,
   output logic [W-1:0] cond
);
   logic [W-1:0] masked_n;

   // zeroing acts on the inverted operand, then an XNOR against the invert bit
   assign masked_n = ~raw | {W{zero_en}};
   assign cond     = ~(masked_n ^ {W{inv_en}});
endmodule

// File: rtl/alu_slice.sv
module alu_slice (
   input  logic a,
   input  logic b,
   input  logic cin,
   output logic sum,
   output logic cout,
   output logic conj
);
   logic p1, g1, g2;

   // first half adder: its carry term doubles as the AND function
   assign p1   = a ^ b;
   assign g1   = a & b;
   // second half adder folds in the carry from the slice below
   assign sum  = p1 ^ cin;
   assign g2   = p1 & cin;
   assign cout = g1 | g2;
   assign conj = g1;
endmodule

// File: rtl/alu_pick.sv
module alu_pick #(
   parameter int W = 16
) (
   input  logic         sel,
   input  logic [W-1:0] when_one,
   input  logic [W-1:0] when_zero,
   output logic [W-1:0] picked
);
   assign picked = ({W{sel}} & when_one) | ({W{~sel}} & when_zero);
endmodule

// File: rtl/alu_core.sv
module alu_core #(
   parameter int W          = 16,
   parameter bit USE_SLICES = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic [W-1:0] conj
);
   generate
      if (USE_SLICES) begin : g_ripple
         logic [W-1:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            if (i < W - 1) begin : g_full
               alu_slice slice_i (
                  .a(a[i]), .b(b[i]), .cin(carry[i]),
                  .sum(sum[i]), .cout(carry[i+1]), .conj(conj[i])
               );
            end else begin : g_top
               // top slice: carry out is not built
               assign sum[i]  = a[i] ^ b[i] ^ carry[i];
               assign conj[i] = a[i] & b[i];
            end
         end
      end else begin : g_behav
         assign sum  = a + b;
         assign conj = a & b;
      end
   endgenerate
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
   import ralu_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter bit USE_SLICES = 1'b1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic [CTL_W-1:0] ctl,
   input  logic [WIDTH-1:0] imm,
   input  logic             sel_imm,
   output logic [WIDTH-1:0] res
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("ripple_alu: WIDTH must be at least 2");
      end
   endgenerate

   logic [MSB:0] xc, yc, sum_v, conj_v, fsel_v, core_v;

   alu_cond #(.W(WIDTH)) cond_x_i (
      .raw(x), .zero_en(ctl[B_ZX]), .inv_en(ctl[B_NX]), .cond(xc));
   alu_cond #(.W(WIDTH)) cond_y_i (
      .raw(y), .zero_en(ctl[B_ZY]), .inv_en(ctl[B_NY]), .cond(yc));

   alu_core #(.W(WIDTH), .USE_SLICES(USE_SLICES)) core_i (
      .a(xc), .b(yc), .sum(sum_v), .conj(conj_v));

   alu_pick #(.W(WIDTH)) fn_pick_i (
      .sel(ctl[B_F]), .when_one(sum_v), .when_zero(conj_v), .picked(fsel_v));

   assign core_v = fsel_v ^ {WIDTH{ctl[B_NO]}};

   alu_pick #(.W(WIDTH)) imm_pick_i (
      .sel(sel_imm), .when_one(imm), .when_zero(core_v), .picked(res));
endmodule

// File: rtl/ralu_chk.sv
module ralu_chk
   import ralu_pkg::*;
#(
   parameter int W = 16
) (
   input logic [W-1:0]     x,
   input logic [W-1:0]     y,
   input logic [CTL_W-1:0] ctl,
   input logic [W-1:0]     imm,
   input logic             sel_imm,
   input logic [W-1:0]     xc,
   input logic [W-1:0]     yc,
   input logic [W-1:0]     sum_v,
   input logic [W-1:0]     conj_v,
   input logic [W-1:0]     res
);
   logic known;
   assign known = !$isunknown({x, y, ctl, imm, sel_imm});

   always_comb begin
      if (known) begin
         // R1
         x_cond_chk: assert (ctl[B_ZX] ? (xc == {W{ctl[B_NX]}})
                                       : (xc == (ctl[B_NX] ? ~x : x)));
         // R2
         y_cond_chk: assert (ctl[B_ZY] ? (yc == {W{ctl[B_NY]}})
                                       : (yc == (ctl[B_NY] ? ~y : y)));
         // R3
         sum_chk: assert (sum_v == W'(xc + yc));
         // R4
         conj_chk: assert (conj_v == (xc & yc));
         // R5
         invert_chk: assert (sel_imm ||
            res == ((ctl[B_F] ? sum_v : conj_v) ^ {W{ctl[B_NO]}}));
         // R6
         imm_chk: assert (!sel_imm || res == imm);
      end
   end
endmodule

bind ripple_alu ralu_chk #(.W(WIDTH)) chk_i (
   .x(x), .y(y), .ctl(ctl), .imm(imm), .sel_imm(sel_imm),
   .xc(xc), .yc(yc), .sum_v(sum_v), .conj_v(conj_v), .res(res)
);

// File: tb/ripple_alu_tb_top.sv
module ripple_alu_tb_top;
   import ralu_pkg::*;

   localparam int W = 16;
   localparam int ALL_CTL = 1 << CTL_W;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] x = '0, y = '0, imm = '0;
   logic [5:0]   ctl = '0;
   logic         sel_imm = 1'b0;
   logic [W-1:0] res;
   int           n_chk = 0, n_bad = 0;
   bit           done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   ripple_alu #(.WIDTH(W)) dut_i (
      .x(x), .y(y), .ctl(ctl), .imm(imm), .sel_imm(sel_imm), .res(res));

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h (x=%h y=%h ctl=%b)", tag, got, exp, x, y, ctl);
      end
   endtask

   // drive after a rising edge, sample at the falling edge
   task automatic apply(input logic [W-1:0] xa, input logic [W-1:0] ya,
                        input logic [5:0] c, input logic s, input logic [W-1:0] im);
      @(posedge clk);
      #1;
      x = xa; y = ya; ctl = c; sel_imm = s; imm = im;
      @(negedge clk);
   endtask

   function automatic logic [W-1:0] cond_of(input logic [W-1:0] v, input logic z, input logic n);
      logic [W-1:0] t;
      t = z ? '0 : v;
      return n ? ~t : t;
   endfunction

   task automatic t_idle();
      apply('0, '0, '0, 1'b0, '0);
      chk("R4 idle", res, '0);
   endtask

   task automatic t_cond();
      logic [W-1:0] a = 16'hA5C3, b = 16'h3C96;
      // observe X conditioning through y=all ones (y zeroed+inverted), AND, no invert
      apply(a, b, 6'b001100, 1'b0, '0); chk("R1 pass", res, a);
      apply(a, b, 6'b011100, 1'b0, '0); chk("R1 invert", res, ~a);
      apply(a, b, 6'b101100, 1'b0, '0); chk("R1 zero", res, '0);
      apply(a, b, 6'b111100, 1'b0, '0); chk("R1 ones", res, '1);
      apply(a, b, 6'b110000, 1'b0, '0); chk("R2 pass", res, b);
      apply(a, b, 6'b110100, 1'b0, '0); chk("R2 invert", res, ~b);
      apply(a, b, 6'b111000, 1'b0, '0); chk("R2 zero", res, '0);
      apply(a, b, 6'b111100, 1'b0, '0); chk("R2 ones", res, '1);
   endtask

   task automatic t_func();
      for (int i = 0; i < 12; i++) begin
         logic [W-1:0] a = W'($urandom), b = W'($urandom);
         apply(a, b, 6'b000010, 1'b0, '0); chk("R3 add", res, W'(a + b));
         apply(a, b, 6'b000000, 1'b0, '0); chk("R4 and", res, a & b);
         apply(a, b, 6'b000011, 1'b0, '0); chk("R5 inv add", res, ~W'(a + b));
         apply(a, b, 6'b000001, 1'b0, '0); chk("R5 inv and", res, ~(a & b));
      end
   endtask

   task automatic t_imm();
      for (int c = 0; c < ALL_CTL; c += 7) begin
         logic [W-1:0] a = W'($urandom), b = W'($urandom), im = W'($urandom);
         logic [W-1:0] xa, yb, r;
         apply(a, b, 6'(c), 1'b1, im);
         chk("R6 imm", res, im);
         xa = cond_of(a, c[5], c[4]);
         yb = cond_of(b, c[3], c[2]);
         r  = (c[1] ? W'(xa + yb) : (xa & yb)) ^ {W{c[0]}};
         apply(a, b, 6'(c), 1'b0, im);
         chk("R6 alu", res, r);
      end
   endtask

   task automatic t_codes();
      logic [5:0] codes [18] = '{OP_ZERO, OP_ONE, OP_MONE, OP_X, OP_Y, OP_NOTX,
         OP_NOTY, OP_NEGX, OP_NEGY, OP_XP1, OP_YP1, OP_XM1, OP_YM1, OP_ADD,
         OP_XMY, OP_YMX, OP_AND, OP_OR};
      for (int r = 0; r < 4; r++) begin
         logic [W-1:0] a = W'($urandom), b = W'($urandom);
         for (int k = 0; k < 18; k++) begin
            logic [W-1:0] e;
            case (k)
               0: e = '0;          1: e = W'(1);      2: e = '1;
               3: e = a;           4: e = b;          5: e = ~a;
               6: e = ~b;          7: e = W'(-a);     8: e = W'(-b);
               9: e = W'(a + 1);  10: e = W'(b + 1); 11: e = W'(a - 1);
              12: e = W'(b - 1);  13: e = W'(a + b); 14: e = W'(a - b);
              15: e = W'(b - a);  16: e = a & b;     default: e = a | b;
            endcase
            apply(a, b, codes[k], 1'b0, '0);
            chk($sformatf("R7 code %b", codes[k]), res, e);
         end
      end
   endtask

   task automatic t_ripple();
      apply('1, 16'h0001, OP_ADD, 1'b0, '0); chk("R8 wrap", res, '0);
      apply(16'h7FFF, 16'h0001, OP_ADD, 1'b0, '0); chk("R8 to msb", res, 16'h8000);
      apply('1, '1, OP_ADD, 1'b0, '0); chk("R8 drop carry", res, 16'hFFFE);
      apply(16'h0000, 16'h0000, OP_XP1, 1'b0, '0); chk("R8 inc zero", res, 16'h0001);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle();
      t_cond();
      t_func();
      t_imm();
      t_codes();
      t_ripple();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule